// File: doc/BRIEF.md
# Framed PRBS23 Pattern Checker

This block watches a four-lane, byte-wide stream where every byte carries a control flag. It checks the stream against framed PRBS23 test patterns. A frame opens with a start code on lane 0. One preamble column follows and is not checked. Payload bytes then run in lane order, lane 0 first, and a terminate code ends the frame. Idle codes fill the gap before the next frame.

On every start code the checker reseeds its own PRBS23 generator, so each frame is checked on its own. It counts payload bytes that do not match in a saturating counter. It raises a sticky flag when the framing or the idle gap is wrong. It reports lock once a whole frame has arrived without error. The mode select and the source select are sampled when the checker is switched on or given a soft reset. The source select is only held and driven out again; the checking does not use it.

Top module: `prbs23_frame_chk`

## Requirements
- R1: After reset the checker is disabled, and the counter, lock and framing flag are all 0. While `chk_en` is 0, the stream has no effect, the counter holds its value and lock reads 0.
- R2: `pat_sel` and `src_sel` are sampled only in a clear cycle (see R10), and `src_sel_q` drives out the sampled source bit. Code 010 selects the free-length mode and 011 the fixed-length mode. Any other code leaves the checker idle, so nothing is counted and lock stays 0.
- R3: A start code is lane 0 with its control flag set and value 8'hFB. The column after it is preamble and is not checked. Payload starts at lane 0 of the next column. The expected payload comes from x^23+x^18+1, reseeded to all ones at every start code. Each step feeds back s[22]^s[17], and each byte takes 8 such bits with the first bit in bit 7.
- R4: A payload byte that has its control flag set, or whose value differs from the expected one, adds 1 to `err_cnt`. The counter saturates at 16'hFFFF.
- R5: In mode 011 the payload is exactly SHORT_LEN bytes (13458 by default). The next byte position must hold the terminate code, which is a control byte of value 8'hFD. If it does not, a framing error is raised.
- R6: In mode 010 the payload ends at the first terminate code, whatever its length.
- R7: Each lane must carry at least one idle code (a control byte of value 8'hBC) between a terminate and the next start. A start code that arrives without this, or in the middle of a payload, raises a framing error.
- R8: Lock sets when a frame ends correctly with no mismatched byte. It clears on a framing error or when the checker is disabled. Mismatches alone do not clear it.
- R9: `frame_err` is sticky. Once set, it stays set until the next clear.
- R10: A clear happens in a cycle where `soft_rst` is 1 or `chk_en` rises. It zeroes the counter, lock and framing flag, and the stream is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear and sample of the selects |
| chk_en | input | 1 | Checker enable |
| pat_sel | input | 3 | Pattern mode select |
| src_sel | input | 1 | Source select, 0 receive path, 1 transmit path |
| rx_data | input | 8*LANES (32) | Column of bytes, lane 0 in bits 7:0 |
| rx_ctrl | input | LANES (4) | Control flag for each lane |
| err_cnt | output | CNT_W (16) | Saturating count of mismatched bytes |
| locked | output | 1 | Set after a clean frame |
| frame_err | output | 1 | Sticky framing or gap error |
| src_sel_q | output | 1 | Sampled source select |

## Verification
The bench places the fixed-length terminate in the middle of a column (lane 2). It omits that terminate and also cuts a frame short with a fresh start code. A design that gets the byte index wrong by one position would report a framing error on every good frame, or would miss the error on a bad one. One frame leaves out the gap idles, which catches a checker that never looks at the gap. A frame with more than 65535 bad bytes shows whether the counter wraps. Frames sent while disabled or under a reserved mode code show whether the checker counts when it should stay silent. Two clean frames in a row detect a design that does not reseed at the start code, because the second frame would fail.

// File: rtl/prbs23_chk_pkg.sv
package prbs23_chk_pkg;
   localparam logic [7:0] SYM_START = 8'hFB;
   localparam logic [7:0] SYM_TERM  = 8'hFD;
   localparam logic [7:0] SYM_IDLE  = 8'hBC;
   localparam logic [2:0] MODE_FULL  = 3'b010;
   localparam logic [2:0] MODE_SHORT = 3'b011;
   typedef enum logic [1:0] {ST_HUNT, ST_PRE, ST_PAY, ST_GAP} chk_state_e;
endpackage

// File: rtl/chk_prbs_gen.sv
module chk_prbs_gen #(
   parameter int          LANES = 4,
   parameter logic [22:0] SEED  = 23'h7FFFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reseed,
   input  logic               advance,
   output logic [8*LANES-1:0] exp_bytes
);
   localparam int NB = 8 * LANES;

   logic [22:0] st, st_nxt;

   // Unrolled serial generator: NB steps per column, first bit to bit 7.
   always_comb begin
      logic [22:0] s;
      logic        b;
      s = st;
      exp_bytes = '0;
      for (int k = 0; k < NB; k++) begin
         b = s[22] ^ s[17];
         s = {s[21:0], b};
         exp_bytes[(k / 8) * 8 + 7 - (k % 8)] = b;
      end
      st_nxt = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st <= SEED;
      else if (reseed)  st <= SEED;
      else if (advance) st <= st_nxt;
   end
endmodule

// File: rtl/chk_lane_dec.sv
module chk_lane_dec
   import prbs23_chk_pkg::*;
(
   input  logic [7:0] d,
   input  logic       c,
   output logic       is_term,
   output logic       is_idle
);
   assign is_term = c && (d == SYM_TERM);
   assign is_idle = c && (d == SYM_IDLE);
endmodule

// File: rtl/chk_sat_cnt.sv
module chk_sat_cnt #(
   parameter int W  = 16,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [IW-1:0] inc,
   output logic [W-1:0]  cnt
);
   logic [W:0] sum;
   assign sum = {1'b0, cnt} + (W+1)'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (sum[W]) cnt <= '1;
      else             cnt <= sum[W-1:0];
   end
endmodule

// File: rtl/prbs23_frame_chk.sv
module prbs23_frame_chk
   import prbs23_chk_pkg::*;
#(
   parameter int          LANES     = 4,
   parameter int          SHORT_LEN = 13458,
   parameter int          CNT_W     = 16,
   parameter logic [22:0] SEED      = 23'h7FFFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               chk_en,
   input  logic [2:0]         pat_sel,
   input  logic               src_sel,
   input  logic [8*LANES-1:0] rx_data,
   input  logic [LANES-1:0]   rx_ctrl,
   output logic [CNT_W-1:0]   err_cnt,
   output logic               locked,
   output logic               frame_err,
   output logic               src_sel_q
);
   localparam int BC_W = $clog2(SHORT_LEN + LANES + 1);
   localparam int IW   = $clog2(LANES + 1);

   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("LANES out of range");
   end
   if (SHORT_LEN < LANES) begin : g_bad_len
      $error("SHORT_LEN must cover at least one column");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W too small");
   end

   chk_state_e         state;
   logic [BC_W-1:0]    bcnt;
   logic [LANES-1:0]   seen_k;
   logic               frame_bad, en_q;
   logic [2:0]         pat_q;
   logic [LANES-1:0]   ln_t, ln_k, t_before, pay, term, post, mis;
   logic [8*LANES-1:0] exp_bytes;
   logic [IW-1:0]      nmis, inc;
   logic               clr, active, is_short, s0, end_col, end_ok;
   logic               reseed, advance, ferr_evt;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      chk_lane_dec u_dec (
         .d       (rx_data[g*8 +: 8]),
         .c       (rx_ctrl[g]),
         .is_term (ln_t[g]),
         .is_idle (ln_k[g])
      );
   end

   assign clr      = soft_rst || (chk_en && !en_q);
   assign is_short = (pat_q == MODE_SHORT);
   assign active   = chk_en && !clr && ((pat_q == MODE_FULL) || is_short);
   assign s0       = rx_ctrl[0] && (rx_data[7:0] == SYM_START);

   // Lane classes: payload, terminate position, after terminate.
   always_comb begin
      logic            acc;
      logic [BC_W:0]   idx;
      acc  = 1'b0;
      nmis = '0;
      for (int i = 0; i < LANES; i++) begin
         t_before[i] = acc;
         acc = acc | ln_t[i];
         idx = {1'b0, bcnt} + (BC_W+1)'(i);
         if (is_short) begin
            pay[i]  = idx <  (BC_W+1)'(SHORT_LEN);
            term[i] = idx == (BC_W+1)'(SHORT_LEN);
            post[i] = idx >  (BC_W+1)'(SHORT_LEN);
         end else begin
            pay[i]  = !t_before[i] && !ln_t[i];
            term[i] = ln_t[i] && !t_before[i];
            post[i] = t_before[i];
         end
         mis[i] = pay[i] && (rx_ctrl[i] || (rx_data[i*8 +: 8] != exp_bytes[i*8 +: 8]));
         nmis   = nmis + IW'(mis[i]);
      end
   end

   assign end_col  = |term;
   assign end_ok   = &(~term | ln_t);
   assign reseed   = active && s0 && (state != ST_PRE);
   assign advance  = active && (state == ST_PAY) && !s0 && !end_col;
   assign inc      = (active && (state == ST_PAY) && !s0) ? nmis : '0;
   assign ferr_evt = active && (((state == ST_PAY) && s0) ||
                                ((state == ST_PAY) && end_col && !end_ok) ||
                                ((state == ST_GAP) && s0 && (seen_k != '1)));

   chk_prbs_gen #(.LANES(LANES), .SEED(SEED)) u_prbs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reseed    (reseed),
      .advance   (advance),
      .exp_bytes (exp_bytes)
   );

   chk_sat_cnt #(.W(CNT_W), .IW(IW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (inc),
      .cnt   (err_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         bcnt      <= '0;
         seen_k    <= '0;
         frame_bad <= 1'b0;
         locked    <= 1'b0;
         frame_err <= 1'b0;
         en_q      <= 1'b0;
         pat_q     <= '0;
         src_sel_q <= 1'b0;
      end else begin
         en_q <= chk_en;
         if (clr) begin
            pat_q     <= pat_sel;
            src_sel_q <= src_sel;
            state     <= ST_HUNT;
            seen_k    <= '0;
            locked    <= 1'b0;
            frame_err <= 1'b0;
         end else if (!active) begin
            state <= ST_HUNT;
            if (!chk_en) locked <= 1'b0;
         end else begin
            unique case (state)
               ST_HUNT: if (s0) state <= ST_PRE;
               ST_PRE: begin
                  state     <= ST_PAY;
                  bcnt      <= '0;
                  frame_bad <= 1'b0;
               end
               ST_PAY: begin
                  if (s0) begin
                     state <= ST_PRE;
                  end else if (end_col) begin
                     if (end_ok) begin
                        state  <= ST_GAP;
                        seen_k <= post & ln_k;
                        if (!frame_bad && (nmis == '0)) locked <= 1'b1;
                     end else begin
                        state <= ST_HUNT;
                     end
                  end else begin
                     if (is_short) bcnt <= bcnt + BC_W'(LANES);
                     if (nmis != '0) frame_bad <= 1'b1;
                  end
               end
               ST_GAP: begin
                  seen_k <= seen_k | ln_k;
                  if (s0) state <= ST_PRE;
               end
               default: state <= ST_HUNT;
            endcase
            if (ferr_evt) begin
               locked    <= 1'b0;
               frame_err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/prbs23_frame_chk_sva.sv
module prbs23_frame_chk_sva #(
   parameter int CNT_W = 16,
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             chk_en,
   input logic             src_sel_q,
   input logic [CNT_W-1:0] err_cnt,
   input logic             locked,
   input logic             frame_err
);
   logic en_d;
   logic clr_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_d <= 1'b0;
      else        en_d <= chk_en;
   end
   assign clr_now = soft_rst || (chk_en && !en_d);

   p_hold_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en && !soft_rst) |=> $stable(err_cnt));

   p_src_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_now |=> $stable(src_sel_q));

   p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_now |=> (err_cnt >= $past(err_cnt)) &&
                   ((err_cnt - $past(err_cnt)) <= CNT_W'(LANES)));

   p_unlock_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |=> !locked);

   p_ferr_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> !locked);

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_now |=> (err_cnt == '0) && !locked && !frame_err);
endmodule

bind prbs23_frame_chk prbs23_frame_chk_sva #(.CNT_W(CNT_W), .LANES(LANES)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .chk_en    (chk_en),
   .src_sel_q (src_sel_q),
   .err_cnt   (err_cnt),
   .locked    (locked),
   .frame_err (frame_err)
);

// File: tb/sim_prbs23_frame_chk.sv
`timescale 1ns/1ps
module sim_prbs23_frame_chk;
   localparam int NL   = 4;
   localparam int SLEN = 13458;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          chk_en = 1'b0;
   logic [2:0]    pat_sel = 3'b011;
   logic          src_sel = 1'b1;
   logic [31:0]   rx_data = {4{8'hBC}};
   logic [3:0]    rx_ctrl = 4'hF;
   logic [15:0]   err_cnt;
   logic          locked, frame_err, src_sel_q;

   int            n_checks = 0;
   int            n_errors = 0;
   logic [22:0]   bs;
   logic [31:0]   col_d;
   logic [3:0]    col_c;
   int            pos = 0;

   always #2.5 clk = ~clk;

   prbs23_frame_chk u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .chk_en(chk_en),
      .pat_sel(pat_sel), .src_sel(src_sel), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
      .err_cnt(err_cnt), .locked(locked), .frame_err(frame_err), .src_sel_q(src_sel_q)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] d, input logic c);
      col_d[pos*8 +: 8] = d;
      col_c[pos] = c;
      pos++;
      if (pos == NL) begin
         rx_data = col_d;
         rx_ctrl = col_c;
         @(negedge clk);
         pos = 0;
      end
   endtask

   task automatic flush(input logic [7:0] d, input logic c);
      while (pos != 0) put(d, c);
   endtask

   task automatic idle_cols(input int n);
      repeat (n * NL) put(8'hBC, 1'b1);
   endtask

   task automatic next_byte(output logic [7:0] v);
      logic b;
      v = '0;
      for (int k = 0; k < 8; k++) begin
         b = bs[22] ^ bs[17];
         bs = {bs[21:0], b};
         v = {v[6:0], b};
      end
   endtask

   // term: 1 terminate code, 0 wrong data byte, 2 nothing
   task automatic send_frame(input int len, input int bad_a, input int bad_b,
                             input int ctl_bad, input bit all_bad,
                             input int term, input int kgap);
      logic [7:0] v;
      flush(8'hBC, 1'b1);
      put(8'hFB, 1'b1);
      repeat (6) put(8'h55, 1'b0);
      put(8'hD5, 1'b0);
      bs = 23'h7FFFFF;
      for (int i = 0; i < len; i++) begin
         next_byte(v);
         if (all_bad || i == bad_a || i == bad_b) v = v ^ 8'hFF;
         put(v, i == ctl_bad);
      end
      if (term == 1) put(8'hFD, 1'b1);
      else if (term == 0) put(8'h00, 1'b0);
      if (kgap > 0) begin
         repeat (NL * kgap) put(8'hBC, 1'b1);
         flush(8'hBC, 1'b1);
      end else begin
         flush(8'h07, 1'b1);
      end
   endtask

   task automatic pulse_soft(input logic [2:0] mode);
      pat_sel = mode;
      soft_rst = 1'b1;
      idle_cols(1);
      soft_rst = 1'b0;
      idle_cols(1);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset err_cnt", err_cnt, 0);
      check("R1 reset locked", locked, 0);
      check("R1 reset frame_err", frame_err, 0);
      check("R2 src not sampled before clear", src_sel_q, 0);
   endtask

   task automatic t_disabled;
      send_frame(40, 3, 5, -1, 0, 1, 1);
      check("R1 disabled no count", err_cnt, 0);
      check("R1 disabled no lock", locked, 0);
   endtask

   task automatic t_short_clean;
      chk_en = 1'b1;
      idle_cols(2);
      check("R2 source exported", src_sel_q, 1);
      check("R8 no lock before frame", locked, 0);
      send_frame(SLEN, -1, -1, -1, 0, 1, 1);
      check("R5 short clean lock", locked, 1);
      check("R3 short clean count", err_cnt, 0);
      send_frame(SLEN, -1, -1, -1, 0, 1, 1);
      check("R3 reseed second frame count", err_cnt, 0);
      check("R5 short no framing error", frame_err, 0);
   endtask

   task automatic t_short_errors;
      send_frame(SLEN, 10, 13000, 500, 0, 1, 1);
      check("R4 three bad bytes", err_cnt, 3);
      check("R8 mismatches keep lock", locked, 1);
      check("R5 good end no framing error", frame_err, 0);
   endtask

   task automatic t_short_noterm;
      send_frame(SLEN, -1, -1, -1, 0, 0, 1);
      check("R5 missing terminate flagged", frame_err, 1);
      check("R8 framing error clears lock", locked, 0);
      check("R4 count kept", err_cnt, 3);
   endtask

   task automatic t_disable_hold;
      chk_en = 1'b0;
      idle_cols(1);
      send_frame(40, 1, 2, -1, 0, 1, 1);
      check("R1 count held while off", err_cnt, 3);
      check("R9 flag held while off", frame_err, 1);
      chk_en = 1'b1;
      idle_cols(1);
      check("R10 enable rise clears count", err_cnt, 0);
      check("R10 enable rise clears flag", frame_err, 0);
   endtask

   task automatic t_full_gap;
      pulse_soft(3'b010);
      send_frame(37, -1, -1, -1, 0, 1, 0);
      check("R6 free length clean lock", locked, 1);
      send_frame(100, 7, 50, -1, 0, 1, 1);
      check("R7 missing gap idles flagged", frame_err, 1);
      check("R6 free length bad bytes", err_cnt, 2);
      check("R8 bad frame no relock", locked, 0);
      send_frame(64, -1, -1, -1, 0, 1, 1);
      check("R8 relock after clean frame", locked, 1);
      check("R9 flag sticky", frame_err, 1);
   endtask

   task automatic t_start_mid;
      pulse_soft(3'b010);
      check("R10 soft reset clears flag", frame_err, 0);
      send_frame(20, -1, -1, -1, 0, 2, 0);
      send_frame(24, -1, -1, -1, 0, 1, 1);
      check("R7 start inside payload flagged", frame_err, 1);
      check("R8 lock after following clean frame", locked, 1);
      check("R3 no mismatch counted", err_cnt, 0);
   endtask

   task automatic t_reserved;
      pulse_soft(3'b101);
      send_frame(40, 1, 2, -1, 0, 1, 1);
      check("R2 reserved mode no count", err_cnt, 0);
      check("R2 reserved mode no lock", locked, 0);
      check("R2 reserved mode no flag", frame_err, 0);
   endtask

   task automatic t_saturate;
      pulse_soft(3'b010);
      send_frame(65600, -1, -1, -1, 1, 1, 1);
      check("R4 saturates", err_cnt, 65535);
      send_frame(40, 0, 1, -1, 0, 1, 1);
      check("R4 stays saturated", err_cnt, 65535);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      t_reset();
      t_disabled();
      t_short_clean();
      t_short_errors();
      t_short_noterm();
      t_disable_hold();
      t_full_gap();
      t_start_mid();
      t_reserved();
      t_saturate();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule